// File: doc/BRIEF.md
# Drum Controller Host Register Interface

This block sits between the host I/O bus and the transfer sequencer of a rotating drum store. Each host access presents a 4-bit register select, a direction and a 16-bit word. The block decodes the select and accepts or rejects the access. It keeps the controller status flags and the two interrupt enables, and it answers reads with status words. Some of those status bits are built live from the drum's current sector position and the drive-ready level.

On the output side, accepted accesses become one-cycle strobes toward the sequencer: start a write, start a read, and load the initial sector address, the initial core address or the final core address. The loaded word is carried on a separate data bus. An odd select is always a director function, which can clear the whole controller, clear pending interrupt causes and set the interrupt enables. The sequencer and the rotational tracker report completion, faults, the last transferred word and the current core address back through event inputs. An interrupt request is raised from the stored cause flags and their enables.

Top module: `drum_host_regs`

## Requirements
- R1: After reset, reply, reject, all strobes and the interrupt request are 0. A status read returns only the live bits: ready (bit 0) and data (bit 3) when the drive is ready, and sector match (bit 13) when the current sector equals the sector field of the stored sector address.
- R2: Every access presented with `accValid` is answered exactly one cycle later by a one-cycle pulse on either `accReply` or `accReject`, never both. Read data is valid in the reply cycle and is 0 otherwise.
- R3: Accepted output selects decode as follows: 4'b0000 pulses `startWrite`, 4'b0100 pulses `startRead`, 4'b1000 pulses `loadSector`, 4'b1100 pulses `loadInitCore` and 4'b1110 pulses `loadFinalCore`. Each pulse comes one cycle after the access, with the written word on `ldData` for the three loads. An accepted start sets busy (status bit 1) and clears the data bit (bit 3).
- R4: Output selects 4'b0010, 4'b0110 and 4'b1010, and input selects other than 4'b0001 to 4'b0100, are rejected and change no state.
- R5: While busy, every output with an even select is rejected with no strobe. Odd selects (director functions) and all legal reads are still accepted.
- R6: A director function word acts bit by bit. Bit 0 clears the controller and pulses `ctlClear`. Bit 1 clears the end-of-operation (bit 4) and alarm (bit 5) flags. Bits 3 and 4 are loaded as the end-of-operation and alarm interrupt enables.
- R7: Status word layout: 0 ready, 1 busy, 2 interrupt, 3 data (ready and not busy), 4 end of operation, 5 alarm, 9 protect fault, 13 sector match, 15 sector overrange; all other bits read 0.
- R8: `seqDone` sets end of operation and clears busy. Any accepted output clears end of operation, but a completion event in the same cycle wins over that clear.
- R9: `irq` is high exactly when (end of operation and its enable) or (alarm and its enable) hold. Status bit 2 reads the same value.
- R10: Loading the initial core address copies the word into core-address status (select 4'b0011). Either core-address load sets the compare flag when the initial and final addresses are then equal and clears it otherwise. A completion or fault clears the flag.
- R11: A controller clear zeroes busy, all cause flags, the track and the compare flag. It keeps core-address status, data status (select 4'b0100, the last transferred word), the enables and the stored addresses.
- R12: A start whose track field (bits 14:5 of the stored sector address) is at or above NUM_TRACKS issues no strobe and leaves busy clear. It sets sector overrange and alarm instead. Sequencer fault inputs set protect fault or sector overrange, set alarm and clear busy.
- R13: Sector-address status (select 4'b0010) reads {compare flag in bit 15, track in bits 14:5, live current sector in bits 4:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Host access present this cycle |
| accWrite | input | 1 | 1 = output to block, 0 = input from block |
| accSel | input | 4 | Register select |
| wrData | input | 16 | Host output word |
| rdData | output | 16 | Host input word, valid with accReply |
| accReply | output | 1 | Access accepted |
| accReject | output | 1 | Access rejected |
| driveReady | input | 1 | Drum is up to speed and usable |
| curSector | input | 5 | Sector now under the head |
| seqDone | input | 1 | Transfer finished |
| seqProtFault | input | 1 | Transfer stopped on protect fault |
| seqOverrange | input | 1 | Transfer ran past the last track |
| xferWordValid | input | 1 | New transferred word |
| xferWord | input | 16 | Transferred word |
| xferAddrValid | input | 1 | New current core address |
| xferAddr | input | 16 | Current core address |
| startWrite | output | 1 | Start-write strobe |
| startRead | output | 1 | Start-read strobe |
| loadSector | output | 1 | Initial sector address load strobe |
| loadInitCore | output | 1 | Initial core address load strobe |
| loadFinalCore | output | 1 | Final core address load strobe |
| ldData | output | 16 | Word carried with a load strobe |
| ctlClear | output | 1 | Controller clear pulse to sequencer and tracker |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 10-bit track field, a 5-bit sector field and NUM_TRACKS of 320. Random 10-bit track values therefore land on both sides of the overrange limit, so legal starts and refused starts both occur often. Sector positions are sometimes forced onto the stored sector field so that the live match bit is exercised, and director words carry the clear bit often enough for controller clears to interleave with transfers in flight.

// File: rtl/drum_regs_pkg.sv
package drum_regs_pkg;

  // Register selects whose meaning the sequencer and software depend on
  localparam logic [3:0] SEL_START_WR = 4'b0000;
  localparam logic [3:0] SEL_START_RD = 4'b0100;
  localparam logic [3:0] SEL_LD_SECT  = 4'b1000;
  localparam logic [3:0] SEL_LD_ICORE = 4'b1100;
  localparam logic [3:0] SEL_LD_FCORE = 4'b1110;
  localparam logic [3:0] SEL_RD_STAT  = 4'b0001;
  localparam logic [3:0] SEL_RD_SECT  = 4'b0010;
  localparam logic [3:0] SEL_RD_CORE  = 4'b0011;
  localparam logic [3:0] SEL_RD_DATA  = 4'b0100;

  // Director word bits
  localparam int DF_CLEAR   = 0;
  localparam int DF_CLR_INT = 1;
  localparam int DF_EN_EOP  = 3;
  localparam int DF_EN_ALM  = 4;

  // Status word bits
  localparam int ST_READY = 0;
  localparam int ST_BUSY  = 1;
  localparam int ST_INT   = 2;
  localparam int ST_DATA  = 3;
  localparam int ST_EOP   = 4;
  localparam int ST_ALARM = 5;
  localparam int ST_PROTF = 9;
  localparam int ST_SCMP  = 13;
  localparam int ST_OVR   = 15;

  // Strobes from control to datapath, one cycle of decoded access
  typedef struct packed {
    logic       accept;
    logic       isRead;
    logic [3:0] sel;
    logic       dirFunc;
    logic       startWr;
    logic       startRd;
    logic       ldSect;
    logic       ldICore;
    logic       ldFCore;
  } regStrb_t;

  function automatic logic outSelLegal(input logic [3:0] s);
    return s[0] || (s == SEL_START_WR) || (s == SEL_START_RD) ||
           (s == SEL_LD_SECT) || (s == SEL_LD_ICORE) || (s == SEL_LD_FCORE);
  endfunction

  function automatic logic inSelLegal(input logic [3:0] s);
    return (s == SEL_RD_STAT) || (s == SEL_RD_SECT) ||
           (s == SEL_RD_CORE) || (s == SEL_RD_DATA);
  endfunction

endpackage

// File: rtl/drum_reg_ctrl.sv
module drum_reg_ctrl
  import drum_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic [3:0] accSel,
  input  logic       busyNow,
  output regStrb_t   strb,
  output logic       accReply,
  output logic       accReject
);

  localparam int NUM_SEL = 16;

  logic [NUM_SEL-1:0] outLegalMap;
  logic [NUM_SEL-1:0] inLegalMap;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_selMap
    assign outLegalMap[s] = outSelLegal(4'(s));
    assign inLegalMap[s]  = inSelLegal(4'(s));
  end

  logic busyBlock;
  logic accOk;

  always_comb begin
    busyBlock = accWrite && !accSel[0] && busyNow;
    accOk     = accValid && (accWrite ? (outLegalMap[accSel] && !busyBlock)
                                      : inLegalMap[accSel]);
    strb         = '0;
    strb.accept  = accOk;
    strb.isRead  = accOk && !accWrite;
    strb.sel     = accSel;
    strb.dirFunc = accOk && accWrite && accSel[0];
    strb.startWr = accOk && accWrite && (accSel == SEL_START_WR);
    strb.startRd = accOk && accWrite && (accSel == SEL_START_RD);
    strb.ldSect  = accOk && accWrite && (accSel == SEL_LD_SECT);
    strb.ldICore = accOk && accWrite && (accSel == SEL_LD_ICORE);
    strb.ldFCore = accOk && accWrite && (accSel == SEL_LD_FCORE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReply  <= 1'b0;
      accReject <= 1'b0;
    end else begin
      accReply  <= accOk;
      accReject <= accValid && !accOk;
    end
  end

endmodule

// File: rtl/drum_reg_dpath.sv
module drum_reg_dpath
  import drum_regs_pkg::*;
#(
  parameter int TRACK_W    = 10,
  parameter int SECT_W     = 5,
  parameter int NUM_TRACKS = 320,
  localparam int ADDR_W    = TRACK_W + SECT_W,
  localparam int DATA_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              driveReady,
  input  logic [SECT_W-1:0] curSector,
  input  logic              seqDone,
  input  logic              seqProtFault,
  input  logic              seqOverrange,
  input  logic              xferWordValid,
  input  logic [DATA_W-1:0] xferWord,
  input  logic              xferAddrValid,
  input  logic [DATA_W-1:0] xferAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              startWrite,
  output logic              startRead,
  output logic              loadSector,
  output logic              loadInitCore,
  output logic              loadFinalCore,
  output logic [DATA_W-1:0] ldData,
  output logic              ctlClear,
  output logic              irq,
  output logic              busyNow
);

  localparam logic [TRACK_W-1:0] TRK_LAST = TRACK_W'(NUM_TRACKS - 1);

  logic               busyR, eopR, alarmR, ovrR, pfR;
  logic               enEopR, enAlmR;
  logic [ADDR_W-1:0]  sectAddrR;
  logic [TRACK_W-1:0] trackR;
  logic               cmpR;
  logic [DATA_W-1:0]  iCoreR, fCoreR, coreStatR, dataStatR;

  logic               trkOk;
  logic               intNow;
  logic [DATA_W-1:0]  statWord, sectWord, readMux;

  always_comb begin
    trkOk  = sectAddrR[SECT_W +: TRACK_W] <= TRK_LAST;
    intNow = (eopR && enEopR) || (alarmR && enAlmR);

    statWord           = '0;
    statWord[ST_READY] = driveReady;
    statWord[ST_BUSY]  = busyR;
    statWord[ST_INT]   = intNow;
    statWord[ST_DATA]  = driveReady && !busyR;
    statWord[ST_EOP]   = eopR;
    statWord[ST_ALARM] = alarmR;
    statWord[ST_PROTF] = pfR;
    statWord[ST_SCMP]  = curSector == sectAddrR[SECT_W-1:0];
    statWord[ST_OVR]   = ovrR;

    sectWord = {cmpR, trackR, curSector};

    unique case (strb.sel)
      SEL_RD_STAT: readMux = statWord;
      SEL_RD_SECT: readMux = sectWord;
      SEL_RD_CORE: readMux = coreStatR;
      SEL_RD_DATA: readMux = dataStatR;
      default:     readMux = '0;
    endcase
  end

  assign irq     = intNow;
  assign busyNow = busyR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0; eopR <= 1'b0; alarmR <= 1'b0; ovrR <= 1'b0; pfR <= 1'b0;
      enEopR <= 1'b0; enAlmR <= 1'b0;
      sectAddrR <= '0; trackR <= '0; cmpR <= 1'b0;
      iCoreR <= '0; fCoreR <= '0; coreStatR <= '0; dataStatR <= '0;
      rdData <= '0; ldData <= '0;
      startWrite <= 1'b0; startRead <= 1'b0;
      loadSector <= 1'b0; loadInitCore <= 1'b0; loadFinalCore <= 1'b0;
      ctlClear <= 1'b0;
    end else begin
      startWrite    <= 1'b0;
      startRead     <= 1'b0;
      loadSector    <= 1'b0;
      loadInitCore  <= 1'b0;
      loadFinalCore <= 1'b0;
      ctlClear      <= 1'b0;
      ldData        <= '0;
      rdData        <= '0;

      // Lowest priority: any accepted output drops end of operation
      if (strb.accept && !strb.isRead) eopR <= 1'b0;

      if (strb.dirFunc) begin
        if (wrData[DF_CLR_INT]) begin
          eopR   <= 1'b0;
          alarmR <= 1'b0;
        end
        enEopR <= wrData[DF_EN_EOP];
        enAlmR <= wrData[DF_EN_ALM];
      end

      // Sequencer events override the host-side clears above
      if (seqDone) begin
        eopR <= 1'b1; busyR <= 1'b0; cmpR <= 1'b0;
      end
      if (seqProtFault) begin
        pfR <= 1'b1; alarmR <= 1'b1; busyR <= 1'b0; cmpR <= 1'b0;
      end
      if (seqOverrange) begin
        ovrR <= 1'b1; alarmR <= 1'b1; busyR <= 1'b0; cmpR <= 1'b0;
      end
      if (xferWordValid) dataStatR <= xferWord;
      if (xferAddrValid) coreStatR <= xferAddr;

      if (strb.startWr || strb.startRd) begin
        if (trkOk) begin
          busyR      <= 1'b1;
          startWrite <= strb.startWr;
          startRead  <= strb.startRd;
        end else begin
          ovrR   <= 1'b1;
          alarmR <= 1'b1;
        end
      end

      if (strb.ldSect) begin
        sectAddrR  <= wrData[ADDR_W-1:0];
        trackR     <= wrData[SECT_W +: TRACK_W];
        ldData     <= wrData;
        loadSector <= 1'b1;
      end
      if (strb.ldICore) begin
        iCoreR       <= wrData;
        coreStatR    <= wrData;
        cmpR         <= wrData == fCoreR;
        ldData       <= wrData;
        loadInitCore <= 1'b1;
      end
      if (strb.ldFCore) begin
        fCoreR        <= wrData;
        cmpR          <= wrData == iCoreR;
        ldData        <= wrData;
        loadFinalCore <= 1'b1;
      end

      // Highest priority: controller clear
      if (strb.dirFunc && wrData[DF_CLEAR]) begin
        ctlClear <= 1'b1;
        busyR <= 1'b0; eopR <= 1'b0; alarmR <= 1'b0; ovrR <= 1'b0; pfR <= 1'b0;
        trackR <= '0; cmpR <= 1'b0;
      end

      if (strb.isRead) rdData <= readMux;
    end
  end

endmodule

// File: rtl/drum_host_regs.sv
module drum_host_regs
  import drum_regs_pkg::*;
#(
  parameter int TRACK_W    = 10,
  parameter int SECT_W     = 5,
  parameter int NUM_TRACKS = 320,
  localparam int DATA_W    = TRACK_W + SECT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [3:0]        accSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              accReply,
  output logic              accReject,
  input  logic              driveReady,
  input  logic [SECT_W-1:0] curSector,
  input  logic              seqDone,
  input  logic              seqProtFault,
  input  logic              seqOverrange,
  input  logic              xferWordValid,
  input  logic [DATA_W-1:0] xferWord,
  input  logic              xferAddrValid,
  input  logic [DATA_W-1:0] xferAddr,
  output logic              startWrite,
  output logic              startRead,
  output logic              loadSector,
  output logic              loadInitCore,
  output logic              loadFinalCore,
  output logic [DATA_W-1:0] ldData,
  output logic              ctlClear,
  output logic              irq
);

  regStrb_t strb;
  logic     busyNow;

  drum_reg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .accSel    (accSel),
    .busyNow   (busyNow),
    .strb      (strb),
    .accReply  (accReply),
    .accReject (accReject)
  );

  drum_reg_dpath #(
    .TRACK_W    (TRACK_W),
    .SECT_W     (SECT_W),
    .NUM_TRACKS (NUM_TRACKS)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (wrData),
    .driveReady    (driveReady),
    .curSector     (curSector),
    .seqDone       (seqDone),
    .seqProtFault  (seqProtFault),
    .seqOverrange  (seqOverrange),
    .xferWordValid (xferWordValid),
    .xferWord      (xferWord),
    .xferAddrValid (xferAddrValid),
    .xferAddr      (xferAddr),
    .rdData        (rdData),
    .startWrite    (startWrite),
    .startRead     (startRead),
    .loadSector    (loadSector),
    .loadInitCore  (loadInitCore),
    .loadFinalCore (loadFinalCore),
    .ldData        (ldData),
    .ctlClear      (ctlClear),
    .irq           (irq),
    .busyNow       (busyNow)
  );

endmodule

// File: rtl/drum_host_regs_chk.sv
module drum_host_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accWrite,
  input logic [3:0]  accSel,
  input logic        wrDataClr,
  input logic        accReply,
  input logic        accReject,
  input logic        startWrite,
  input logic        startRead,
  input logic        ctlClear,
  input logic        irq,
  input logic        seqDone,
  input logic        seqProtFault,
  input logic        seqOverrange,
  input logic        busyNow
);

  a_r2_single_answer: assert property (@(posedge clk) disable iff (!rstN)
    !(accReply && accReject));

  a_r2_answer_follows_access: assert property (@(posedge clk) disable iff (!rstN)
    (accReply || accReject) |-> $past(accValid));

  a_r4_illegal_output: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && (accSel == 4'b0010 || accSel == 4'b0110 || accSel == 4'b1010))
    |=> accReject);

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !accSel[0] && busyNow)
    |=> (accReject && !startWrite && !startRead));

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startWrite || startRead) |-> (busyNow && $past(!busyNow)));

  a_r6_clear_from_director: assert property (@(posedge clk) disable iff (!rstN)
    ctlClear |-> $past(accValid && accWrite && accSel[0] && wrDataClr));

  a_r11_clear_idles: assert property (@(posedge clk) disable iff (!rstN)
    ctlClear |-> !busyNow);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(seqDone || seqProtFault || seqOverrange || (accValid && accWrite)));

endmodule

bind drum_host_regs drum_host_regs_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accSel       (accSel),
  .wrDataClr    (wrData[0]),
  .accReply     (accReply),
  .accReject    (accReject),
  .startWrite   (startWrite),
  .startRead    (startRead),
  .ctlClear     (ctlClear),
  .irq          (irq),
  .seqDone      (seqDone),
  .seqProtFault (seqProtFault),
  .seqOverrange (seqOverrange),
  .busyNow      (busyNow)
);

// File: tb/sim_drum_host_regs.sv
`timescale 1ns/1ps
module sim_drum_host_regs;

  localparam int NUM_TRACKS = 320;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 0, accWrite = 0;
  logic [3:0]  accSel = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        accReply, accReject;
  logic        driveReady = 1'b1;
  logic [4:0]  curSector = 5'd5;
  logic        seqDone = 0, seqProtFault = 0, seqOverrange = 0;
  logic        xferWordValid = 0, xferAddrValid = 0;
  logic [15:0] xferWord = '0, xferAddr = '0;
  logic        startWrite, startRead, loadSector, loadInitCore, loadFinalCore;
  logic [15:0] ldData;
  logic        ctlClear, irq;

  always #2 clk = ~clk;

  drum_host_regs #(.NUM_TRACKS(NUM_TRACKS)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSel(accSel), .wrData(wrData), .rdData(rdData), .accReply(accReply),
    .accReject(accReject), .driveReady(driveReady), .curSector(curSector),
    .seqDone(seqDone), .seqProtFault(seqProtFault), .seqOverrange(seqOverrange),
    .xferWordValid(xferWordValid), .xferWord(xferWord),
    .xferAddrValid(xferAddrValid), .xferAddr(xferAddr),
    .startWrite(startWrite), .startRead(startRead), .loadSector(loadSector),
    .loadInitCore(loadInitCore), .loadFinalCore(loadFinalCore),
    .ldData(ldData), .ctlClear(ctlClear), .irq(irq)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // Reference state
  logic        mBusy, mEop, mAlarm, mOvr, mPf, mEnE, mEnA, mCmp;
  logic [14:0] mSect;
  logic [9:0]  mTrack;
  logic [15:0] mICore, mFCore, mCore, mData;

  // Expected outputs of the current step
  logic [1:0]  eResp;
  logic [15:0] eRd, eLd;
  logic [5:0]  eStrb;
  logic        eIrq, eLoad, eRead;
  string       eTag;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] statusWord();
    logic [15:0] w = '0;
    w[0]  = driveReady;
    w[1]  = mBusy;
    w[2]  = (mEop && mEnE) || (mAlarm && mEnA);
    w[3]  = driveReady && !mBusy;
    w[4]  = mEop;
    w[5]  = mAlarm;
    w[9]  = mPf;
    w[13] = curSector == mSect[4:0];
    w[15] = mOvr;
    return w;
  endfunction

  task automatic modelStep();
    logic outLegal, inLegal, acc, isDir, trkOk;
    outLegal = accSel[0] || accSel inside {4'h0, 4'h4, 4'h8, 4'hC, 4'hE};
    inLegal  = accSel inside {4'h1, 4'h2, 4'h3, 4'h4};
    acc   = accValid && (accWrite ? (outLegal && !(!accSel[0] && mBusy)) : inLegal);
    isDir = acc && accWrite && accSel[0];
    trkOk = mSect[14:5] < NUM_TRACKS;
    eResp = {acc, accValid && !acc};
    eRead = acc && !accWrite;
    eRd = '0;
    if (eRead) begin
      case (accSel)
        4'h1: eRd = statusWord();
        4'h2: eRd = {mCmp, mTrack, curSector};
        4'h3: eRd = mCore;
        default: eRd = mData;
      endcase
    end
    eStrb[5] = acc && accWrite && accSel == 4'h0 && trkOk;
    eStrb[4] = acc && accWrite && accSel == 4'h4 && trkOk;
    eStrb[3] = acc && accWrite && accSel == 4'h8;
    eStrb[2] = acc && accWrite && accSel == 4'hC;
    eStrb[1] = acc && accWrite && accSel == 4'hE;
    eStrb[0] = isDir && wrData[0];
    eLoad = |eStrb[3:1];
    eLd = eLoad ? wrData : '0;

    // Tag by kind of access
    if (!accValid) eTag = "R2";
    else if (accWrite && !outLegal) eTag = "R4";
    else if (!accWrite && !inLegal) eTag = "R4";
    else if (accWrite && !accSel[0] && mBusy) eTag = "R5";
    else if (isDir) eTag = wrData[0] ? "R11" : "R6";
    else if (accWrite && (accSel == 4'h0 || accSel == 4'h4)) eTag = trkOk ? "R3" : "R12";
    else if (accWrite) eTag = "R10";
    else if (accSel == 4'h1) eTag = "R7";
    else if (accSel == 4'h2) eTag = "R13";
    else eTag = "R11";

    // State update in priority order
    if (acc && accWrite) mEop = 0;
    if (isDir) begin
      if (wrData[1]) begin mEop = 0; mAlarm = 0; end
      mEnE = wrData[3]; mEnA = wrData[4];
    end
    if (seqDone) begin mEop = 1; mBusy = 0; mCmp = 0; end
    if (seqProtFault) begin mPf = 1; mAlarm = 1; mBusy = 0; mCmp = 0; end
    if (seqOverrange) begin mOvr = 1; mAlarm = 1; mBusy = 0; mCmp = 0; end
    if (xferWordValid) mData = xferWord;
    if (xferAddrValid) mCore = xferAddr;
    if (acc && accWrite && (accSel == 4'h0 || accSel == 4'h4)) begin
      if (trkOk) mBusy = 1; else begin mOvr = 1; mAlarm = 1; end
    end
    if (eStrb[3]) begin mSect = wrData[14:0]; mTrack = wrData[14:5]; end
    if (eStrb[2]) begin mICore = wrData; mCore = wrData; mCmp = wrData == mFCore; end
    if (eStrb[1]) begin mFCore = wrData; mCmp = wrData == mICore; end
    if (eStrb[0]) begin
      mBusy = 0; mEop = 0; mAlarm = 0; mOvr = 0; mPf = 0; mTrack = '0; mCmp = 0;
    end
    eIrq = (mEop && mEnE) || (mAlarm && mEnA);
  endtask

  // Inputs already driven at a negedge; model, clock, compare
  task automatic step();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(eTag, {14'd0, accReply, accReject}, {14'd0, eResp}, "reply/reject");
    if (eRead) check(eTag, rdData, eRd, "read data");
    check(eTag, {10'd0, startWrite, startRead, loadSector, loadInitCore, loadFinalCore, ctlClear},
          {10'd0, eStrb}, "strobes");
    if (eLoad) check("R3", ldData, eLd, "load data");
    check((seqDone ? "R8" : "R9"), {15'd0, irq}, {15'd0, eIrq}, "irq");
    accValid = 0; seqDone = 0; seqProtFault = 0; seqOverrange = 0;
    xferWordValid = 0; xferAddrValid = 0;
  endtask

  task automatic access(logic w, logic [3:0] s, logic [15:0] d);
    accValid = 1; accWrite = w; accSel = s; wrData = d;
    step();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    mBusy = 0; mEop = 0; mAlarm = 0; mOvr = 0; mPf = 0; mEnE = 0; mEnA = 0; mCmp = 0;
    mSect = '0; mTrack = '0; mICore = '0; mFCore = '0; mCore = '0; mData = '0;
    void'($urandom(32'd1752));
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1: reset state through a status read (expected 16'h0009)
    check("R1", {14'd0, accReply, accReject}, 16'd0, "reset response");
    check("R1", {15'd0, irq}, 16'd0, "reset irq");
    access(0, 4'h1, 0);
    // R4: illegal output then illegal input; state readback unchanged
    access(1, 4'h2, 16'hFFFF);
    access(0, 4'h7, 0);
    access(0, 4'h2, 0);
    // R10 / R13: load addresses, equal core addresses set compare
    access(1, 4'h8, (16'd3 << 5) | 16'd7);
    access(1, 4'hE, 16'h0100);
    access(1, 4'hC, 16'h0100);
    access(0, 4'h2, 0);
    access(0, 4'h3, 0);
    access(1, 4'hE, 16'h0180);
    access(0, 4'h2, 0);
    // R6: enable both interrupts
    access(1, 4'h1, 16'h0018);
    // R3: start read, then R5 while busy
    access(1, 4'h4, 0);
    access(0, 4'h1, 0);
    access(1, 4'hC, 16'h0200);
    access(1, 4'h0, 0);
    access(1, 4'h5, 16'h0018);
    // R8: transfer results and completion
    xferWordValid = 1; xferWord = 16'hBEEF; xferAddrValid = 1; xferAddr = 16'h1234;
    seqDone = 1;
    step();
    access(0, 4'h1, 0);
    access(0, 4'h4, 0);
    access(1, 4'hE, 16'h0300);
    // R12: track 400 out of range
    access(1, 4'h8, 16'd400 << 5);
    access(1, 4'h0, 0);
    access(0, 4'h1, 0);
    // R6: clear interrupt causes keeps overrange
    access(1, 4'h3, 16'h001A);
    access(0, 4'h1, 0);
    // R11: controller clear keeps core and data status
    access(1, 4'h1, 16'h0019);
    access(0, 4'h1, 0);
    access(0, 4'h3, 0);
    access(0, 4'h4, 0);

    // Constrained random phase
    for (int i = 0; i < 5000; i++) begin
      accValid   = ($urandom % 10) < 7;
      accWrite   = $urandom % 2;
      accSel     = 4'($urandom % 16);
      wrData     = 16'($urandom);
      if (accWrite && accSel[0] && ($urandom % 8) != 0) wrData[0] = 1'b0;
      driveReady = ($urandom % 16) != 0;
      curSector  = (($urandom % 4) == 0) ? mSect[4:0] : 5'($urandom);
      if (mBusy) begin
        case ($urandom % 20)
          0, 1, 2: seqDone = 1;
          3:       seqProtFault = 1;
          4:       seqOverrange = 1;
          default: ;
        endcase
        xferWordValid = $urandom % 2; xferWord = 16'($urandom);
        xferAddrValid = $urandom % 2; xferAddr = 16'($urandom);
      end
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule